// File: doc/BRIEF.md
# Per-Pin Configurable Input Debouncer

This block cleans up a bank of slow digital input pins, such as buttons, switches and sense lines. Each raw input first passes through a two-flop synchroniser. A filter then lets the cleaned output follow the input only after the input has held a new level for a programmable time. A prescaler divides the system clock down to a 1 µs time base. Each pin (or, in grouped mode, each group of pins) has a 3-bit time code, and the code picks a hold time between 1 µs and 30 ms.

Software programs the time codes through 32-bit register writes made of a write strobe, a byte address and data. Every 32-bit word carries eight 4-bit fields. In each field the low three bits hold the code and the top bit is a per-field write enable. A single write can therefore retune any subset of pins and leave the rest alone. Reading a word returns the stored codes, with every enable position reading as zero.

A build-time option switches the bank to grouped mode. In grouped mode, runs of consecutive pins share one field and the valid code range moves up by one.

Top module: `pin_debounce_bank`

## Requirements
- R1: Field index f maps to configuration word f/8 at byte address 4*(f/8) and to nibble f%8 of that word (bits 4*(f%8)+3 down to 4*(f%8)). In per-pin mode, f is the pin number. Byte address bits [1:0] are ignored.
- R2: A write updates a field's stored code (nibble bits [2:0]) only when bit [3] of that nibble is 1 in the written data. Fields whose nibble bit [3] is 0 keep their old code.
- R3: A read returns the stored code of each field in that field's nibble bits [2:0], with every nibble bit [3] reading 0. A word address past the last implemented word reads 0, and writes to that address change no stored code.
- R4: The time base produces one tick every TICK_DIV clock cycles.
- R5: In per-pin mode, codes 0..6 select hold times of 1, 10, 100, 1000, 10000, 20000 and 30000 ticks. The output takes a new level on the N-th tick for which the synchronised input differs from the output; inputs reach the filter through two flops. Code 7 behaves as code 6.
- R6: If the synchronised input returns to the output level before the hold time ends, the output does not change, and a later change again needs the full hold time.
- R7: When a field's stored code takes a different value, the hold count of the affected pins restarts from zero.
- R8: In grouped mode, pins g*GROUP_PINS to g*GROUP_PINS+GROUP_PINS-1 share field g. Codes 1..7 select the seven hold times in ascending order, and code 0 behaves as code 1.
- R9: After reset all stored codes are 0 and all filtered outputs are 0.
- R10: Each pin filters independently, so pins with different codes, toggled together, change at their own times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for the word at cfg_addr |
| pin_raw | input | NUM_PINS | Raw asynchronous pin inputs |
| pin_filt | output | NUM_PINS | Debounced pin levels |

## Verification
Five table rows each put one pin on its own code and measure the switching edge. The output is checked to be still at the old level one tick before the hold time ends and at the new level once it has ended, so a wrong time-table entry, a missing synchroniser stage or an off-by-one in the hold count each show up.

Several other patterns are tried, and each tells a different fault apart:
- A short pulse followed by a full-length pulse separates a counter that restarts from one that accumulates.
- Changing a code halfway through a hold separates a counter reset on code change from a stale count.
- Two pins toggled together with different codes expose crosstalk between pins.
- Partial-enable writes and out-of-range writes separate per-nibble enables from whole-word writes.
- A grouped-mode instance checks the shared field, the code-0 clamp and the shifted code table.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

   localparam int CODE_W = 3;
   localparam int CNT_W  = 15;

   // Per-pin mode: codes 0..6 valid, 7 folds onto 6.
   // Grouped mode: codes 1..7 valid, 0 folds onto 1; index is code-1.
   function automatic logic [CODE_W-1:0] time_index(input logic [CODE_W-1:0] code,
                                                    input bit grouped);
      if (grouped)
         return (code == 3'd0) ? 3'd0 : code - 3'd1;
      else
         return (code == 3'd7) ? 3'd6 : code;
   endfunction

   // Hold time in 1 us ticks for a time index.
   function automatic logic [CNT_W-1:0] index_ticks(input logic [CODE_W-1:0] idx);
      case (idx)
         3'd0:    return 15'd1;
         3'd1:    return 15'd10;
         3'd2:    return 15'd100;
         3'd3:    return 15'd1000;
         3'd4:    return 15'd10000;
         3'd5:    return 15'd20000;
         default: return 15'd30000;
      endcase
   endfunction

endpackage

// File: rtl/dbn_tick_gen.sv
module dbn_tick_gen #(
   parameter int TICK_DIV = 250
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

   logic [DW-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (div_q == LAST)
         div_q <= '0;
      else
         div_q <= div_q + 1'b1;
   end

   assign tick = (div_q == LAST);

endmodule

// File: rtl/dbn_cfg_regs.sv
module dbn_cfg_regs
   import dbn_pkg::*;
#(
   parameter int NFIELD = 16,
   parameter int ADDR_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [ADDR_W-1:0]        cfg_addr,
   input  logic [31:0]              cfg_wdata,
   output logic [31:0]              cfg_rdata,
   output logic [NFIELD*CODE_W-1:0] field_code,
   output logic [NFIELD-1:0]        field_chg
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] word_idx;
   logic [33:0]      unused_bits;

   assign word_idx    = cfg_addr[ADDR_W-1:2];
   assign unused_bits = {cfg_addr[1:0], cfg_wdata};

   for (genvar f = 0; f < NFIELD; f++) begin : g_field
      localparam int WORD = f / 8;
      localparam int NIB  = f % 8;

      logic              hit;
      logic [CODE_W-1:0] new_code;
      logic [CODE_W-1:0] code_q;
      logic              chg_q;

      assign hit      = cfg_we && (word_idx == IDX_W'(WORD)) && cfg_wdata[4*NIB+3];
      assign new_code = cfg_wdata[4*NIB +: CODE_W];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_q <= '0;
            chg_q  <= 1'b0;
         end else begin
            chg_q <= hit && (new_code != code_q);
            if (hit)
               code_q <= new_code;
         end
      end

      assign field_code[f*CODE_W +: CODE_W] = code_q;
      assign field_chg[f]                   = chg_q;
   end

   always_comb begin
      cfg_rdata = '0;
      for (int j = 0; j < 8; j++) begin
         int f;
         f = int'(word_idx) * 8 + j;
         if (f < NFIELD)
            cfg_rdata[4*j +: CODE_W] = field_code[f*CODE_W +: CODE_W];
      end
   end

endmodule

// File: rtl/dbn_pin_filter.sv
module dbn_pin_filter
   import dbn_pkg::*;
#(
   parameter int GROUPED = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              raw,
   input  logic [CODE_W-1:0] code,
   input  logic              code_chg,
   output logic              sync_o,
   output logic              filt
);
   logic             s1_q, s2_q, filt_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   assign limit = index_ticks(time_index(code, GROUPED != 0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q <= 1'b0;
         s2_q <= 1'b0;
      end else begin
         s1_q <= raw;
         s2_q <= s1_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         filt_q <= 1'b0;
      end else if (code_chg) begin
         cnt_q <= '0;
      end else if (s2_q == filt_q) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (cnt_q >= limit - 1'b1) begin
            filt_q <= s2_q;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign sync_o = s2_q;
   assign filt   = filt_q;

endmodule

// File: rtl/pin_debounce_bank.sv
module pin_debounce_bank
   import dbn_pkg::*;
#(
   parameter int NUM_PINS   = 16,
   parameter int GROUPED    = 0,
   parameter int GROUP_PINS = 16,
   parameter int TICK_DIV   = 250,
   parameter int ADDR_W     = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic [31:0]         cfg_wdata,
   output logic [31:0]         cfg_rdata,
   input  logic [NUM_PINS-1:0] pin_raw,
   output logic [NUM_PINS-1:0] pin_filt
);
   localparam int NFIELD = (GROUPED != 0) ? (NUM_PINS + GROUP_PINS - 1) / GROUP_PINS
                                          : NUM_PINS;
   localparam int NREG   = (NFIELD + 7) / 8;

   if (NUM_PINS < 1)                 begin : g_chk_pins  $error("NUM_PINS must be at least 1");          end
   if (TICK_DIV < 1)                 begin : g_chk_div   $error("TICK_DIV must be at least 1");          end
   if (GROUP_PINS < 1)               begin : g_chk_grp   $error("GROUP_PINS must be at least 1");        end
   if (ADDR_W < 3)                   begin : g_chk_aw    $error("ADDR_W must be at least 3");            end
   if (NREG * 4 > (1 << ADDR_W))     begin : g_chk_span  $error("ADDR_W too small for register span");  end

   logic                     tick;
   logic [NFIELD*CODE_W-1:0] field_code;
   logic [NFIELD-1:0]        field_chg;
   logic [NUM_PINS-1:0]      pin_sync;

   dbn_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   dbn_cfg_regs #(.NFIELD(NFIELD), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .field_code (field_code),
      .field_chg  (field_chg)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int FI = (GROUPED != 0) ? p / GROUP_PINS : p;

      dbn_pin_filter #(.GROUPED(GROUPED)) u_filt (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .raw      (pin_raw[p]),
         .code     (field_code[FI*CODE_W +: CODE_W]),
         .code_chg (field_chg[FI]),
         .sync_o   (pin_sync[p]),
         .filt     (pin_filt[p])
      );
   end

endmodule

// File: rtl/pin_debounce_bank_chk.sv
module pin_debounce_bank_chk #(
   parameter int NUM_PINS = 16,
   parameter int NFIELD   = 16,
   parameter int NREG     = 2,
   parameter int TICK_DIV = 250,
   parameter int ADDR_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick,
   input logic                cfg_we,
   input logic [ADDR_W-1:0]   cfg_addr,
   input logic [31:0]         cfg_wdata,
   input logic [31:0]         cfg_rdata,
   input logic [NFIELD*3-1:0] field_code,
   input logic [NUM_PINS-1:0] pin_sync,
   input logic [NUM_PINS-1:0] pin_filt
);
   logic [31:0] gap_q;
   logic        seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (tick) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else begin
         gap_q <= gap_q + 1;
      end
   end

   AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && seen_q) |-> (gap_q == 32'(TICK_DIV - 1)));                           // R4

   AST_ENABLE_BITS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & 32'h8888_8888) == 32'h0);                                         // R3

   AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg_addr[ADDR_W-1:2]) >= NREG) |-> (cfg_rdata == 32'h0));               // R3

   AST_NO_ENABLE_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && ((cfg_wdata & 32'h8888_8888) == 32'h0)) |=> $stable(field_code));   // R2

   AST_FILT_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_filt != $past(pin_filt)) |-> $past(tick));                                // R5

   AST_FILT_TAKES_SYNC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_filt ^ $past(pin_filt)) & (pin_filt ^ $past(pin_sync))) == '0);          // R6

endmodule

bind pin_debounce_bank pin_debounce_bank_chk #(
   .NUM_PINS (NUM_PINS),
   .NFIELD   (NFIELD),
   .NREG     (NREG),
   .TICK_DIV (TICK_DIV),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .cfg_we     (cfg_we),
   .cfg_addr   (cfg_addr),
   .cfg_wdata  (cfg_wdata),
   .cfg_rdata  (cfg_rdata),
   .field_code (field_code),
   .pin_sync   (pin_sync),
   .pin_filt   (pin_filt)
);

// File: tb/pin_debounce_bank_tb.sv
`timescale 1ns/1ps
module pin_debounce_bank_tb;
   localparam int DIV = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we_a = 1'b0, we_g = 1'b0;
   logic [7:0]  addr_a = '0, addr_g = '0;
   logic [31:0] wdata_a = '0, wdata_g = '0;
   logic [31:0] rdata_a, rdata_g;
   logic [15:0] raw_a = '0, filt_a;
   logic [31:0] raw_g = '0, filt_g;

   int errors = 0;
   int checks = 0;
   logic [2:0] exp_a [16];

   // table: pin, code, hold ticks (R1 R4 R5)
   localparam int NV = 5;
   localparam int VPIN  [NV] = '{0, 9, 13, 6, 14};
   localparam int VCODE [NV] = '{0, 1, 2, 3, 5};
   localparam int VTICK [NV] = '{1, 10, 100, 1000, 20000};

   always #2 clk = ~clk;   // 250 MHz

   pin_debounce_bank #(.NUM_PINS(16), .GROUPED(0), .TICK_DIV(DIV), .ADDR_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(we_a), .cfg_addr(addr_a), .cfg_wdata(wdata_a),
      .cfg_rdata(rdata_a), .pin_raw(raw_a), .pin_filt(filt_a));

   pin_debounce_bank #(.NUM_PINS(32), .GROUPED(1), .GROUP_PINS(16), .TICK_DIV(DIV), .ADDR_W(8)) u_dut_grp (
      .clk(clk), .rst_n(rst_n), .cfg_we(we_g), .cfg_addr(addr_g), .cfg_wdata(wdata_g),
      .cfg_rdata(rdata_g), .pin_raw(raw_g), .pin_filt(filt_g));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic edges(input int k);
      repeat (k) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_a(input logic [7:0] a, input logic [31:0] d);
      we_a = 1'b1; addr_a = a; wdata_a = d;
      @(posedge clk); @(negedge clk);
      we_a = 1'b0;
      if (a[7:2] < 2)
         for (int j = 0; j < 8; j++)
            if (d[4*j+3]) exp_a[a[7:2]*8 + j] = d[4*j +: 3];
   endtask

   task automatic wr_g(input logic [7:0] a, input logic [31:0] d);
      we_g = 1'b1; addr_g = a; wdata_g = d;
      @(posedge clk); @(negedge clk);
      we_g = 1'b0;
   endtask

   function automatic logic [31:0] model_word(input int r);
      logic [31:0] v = '0;
      for (int j = 0; j < 8; j++) v[4*j +: 3] = exp_a[r*8 + j];
      return v;
   endfunction

   task automatic rd_a(input logic [7:0] a, output logic [31:0] d);
      addr_a = a; #1; d = rdata_a;
   endtask

   task automatic chk_words(input string req);
      logic [31:0] d;
      for (int r = 0; r < 2; r++) begin
         rd_a(8'(4*r), d);
         chk(d == model_word(r), req, d, model_word(r));
      end
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog R1..R10 actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      for (int i = 0; i < 16; i++) exp_a[i] = 3'd0;
      edges(3);
      // R9: reset state
      chk(filt_a == 16'h0, "R9 filt after reset", 32'(filt_a), 0);
      chk(filt_g == 32'h0, "R9 grouped filt after reset", filt_g, 0);
      rst_n = 1'b1;
      edges(2);
      chk_words("R9 codes after reset");
      addr_g = 8'h0; #1;
      chk(rdata_g == 0, "R9 grouped word after reset", rdata_g, 0);

      // R2: only nibble 2 enabled (0xB = en + code 3); others carry code 5 with en clear
      wr_a(8'h00, 32'h5555_5B55);
      chk_words("R2 partial enable write");
      rd_a(8'h00, d);
      chk(d == 32'h0000_0300, "R2 word0 value", d, 32'h0000_0300);

      // R3: write to unimplemented word 2 is dropped and it reads 0
      wr_a(8'h08, 32'hFFFF_FFFF);
      rd_a(8'h08, d);
      chk(d == 0, "R3 unmapped read", d, 0);
      chk_words("R3 unmapped write ignored");
      // R1: byte address low bits ignored
      wr_a(8'h07, 32'h0000_D000);   // word1 nibble3 = pin 11 code 5
      chk_words("R1 address low bits ignored");
      chk(exp_a[11] == 3'd5, "R1 pin11 mapping", 32'(exp_a[11]), 5);

      // table: R1 R4 R5 hold time per code
      for (int v = 0; v < NV; v++) begin
         int p;
         p = VPIN[v];
         wr_a(8'(4*(p/8)), (32'h8 | 32'(VCODE[v])) << (4*(p%8)));
         raw_a[p] = 1'b1;
         edges(2 + (VTICK[v]-1)*DIV);
         chk(filt_a[p] == 1'b0, $sformatf("R5 R4 pin%0d code%0d early", p, VCODE[v]), 32'(filt_a[p]), 0);
         edges(DIV);
         chk(filt_a[p] == 1'b1, $sformatf("R5 R1 pin%0d code%0d settled", p, VCODE[v]), 32'(filt_a[p]), 1);
      end
      chk_words("R1 R3 readback after table");

      // R5: code 7 acts as 30000 ticks (pin 11)
      wr_a(8'h04, 32'h0000_F000);
      raw_a[11] = 1'b1;
      edges(2 + 29999*DIV);
      chk(filt_a[11] == 1'b0, "R5 code7 early", 32'(filt_a[11]), 0);
      edges(DIV);
      chk(filt_a[11] == 1'b1, "R5 code7 settled", 32'(filt_a[11]), 1);

      // R10: pin1 code0 and pin10 code3 toggled together
      wr_a(8'h00, 32'h0000_0080);
      wr_a(8'h04, 32'h0000_0B00);
      raw_a[1] = 1'b1; raw_a[10] = 1'b1;
      edges(2 + DIV);
      chk(filt_a[1] == 1'b1, "R10 fast pin", 32'(filt_a[1]), 1);
      chk(filt_a[10] == 1'b0, "R10 slow pin", 32'(filt_a[10]), 0);

      // R6: short pulse on pin3 (code 2 = 100 ticks) rejected, then full hold needed
      wr_a(8'h00, 32'h0000_A000);
      raw_a[3] = 1'b1;
      edges(50*DIV);
      raw_a[3] = 1'b0;
      edges(200*DIV);
      chk(filt_a[3] == 1'b0, "R6 glitch rejected", 32'(filt_a[3]), 0);
      raw_a[3] = 1'b1;
      edges(2 + 99*DIV);
      chk(filt_a[3] == 1'b0, "R6 count restarted", 32'(filt_a[3]), 0);
      edges(DIV);
      chk(filt_a[3] == 1'b1, "R6 full hold passes", 32'(filt_a[3]), 1);

      // R7: code change mid-hold restarts count (pin4 code3 -> code2)
      wr_a(8'h00, 32'h000B_0000);
      raw_a[4] = 1'b1;
      edges(600*DIV);
      chk(filt_a[4] == 1'b0, "R7 mid hold", 32'(filt_a[4]), 0);
      wr_a(8'h00, 32'h000A_0000);
      edges(50*DIV);
      chk(filt_a[4] == 1'b0, "R7 count reset on code change", 32'(filt_a[4]), 0);
      edges(52*DIV);
      chk(filt_a[4] == 1'b1, "R7 new hold elapsed", 32'(filt_a[4]), 1);

      // R8: grouped; field0 code0 (-> 1 tick), field1 code3 (-> 100 ticks)
      wr_g(8'h00, 32'h0000_00B8);
      addr_g = 8'h00; #1;
      chk(rdata_g == 32'h30, "R8 R3 grouped readback", rdata_g, 32'h30);
      raw_g[5] = 1'b1; raw_g[17] = 1'b1; raw_g[20] = 1'b1;
      edges(2 + DIV);
      chk(filt_g[5] == 1'b1, "R8 group0 code0 clamp", 32'(filt_g[5]), 1);
      chk(filt_g[20] == 1'b0, "R8 group1 early", 32'(filt_g[20]), 0);
      edges(98*DIV);
      chk(filt_g[17] == 1'b0 && filt_g[20] == 1'b0, "R8 group1 one tick short",
          32'({filt_g[17], filt_g[20]}), 0);
      edges(DIV);
      chk(filt_g[17] == 1'b1 && filt_g[20] == 1'b1, "R8 group1 shared setting",
          32'({filt_g[17], filt_g[20]}), 3);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule